// File: doc/BRIEF.md
# Transmit Stream Merge Arbiter

This block joins two AXI-Stream sources into one AXI-Stream output on the transmit side of a link-security datapath. The controlled input carries traffic that has been protected. The uncontrolled input carries traffic that passes through untouched. Every beat carries data, byte enables, an end-of-packet flag, a stream identifier and a 16-bit metadata word. All of these fields reach the output unchanged, through one register stage.

The arbiter has no priority setting. The controlled source owns the output by default. Ownership moves to the uncontrolled source only when three things hold: the controlled source sits between packets, it has shown no valid beat for a fixed idle gap, and an uncontrolled beat is waiting. Ownership returns to the controlled source on the cycle after the uncontrolled source's end-of-packet beat is accepted. Packets are never cut into pieces, and any stall at the output reaches the owning input through its ready signal.

The uncontrolled input has an enable pin. While the enable is low, that input is never granted. The data width is a parameter. Elaboration rejects any width other than 64, 128, 256 or 512 bits.

Top module: `txm_merge`

## Requirements
- R1: Every accepted input beat leaves the output exactly once. Its data, byte enables, end flag and stream identifier are unchanged, and beats from the same input keep their order.
- R2: With `META_EN`=1 (the default), the 16-bit metadata of each beat appears unchanged on `m_tuser` alongside that beat. With `META_EN`=0, `m_tuser` is zero.
- R3: While `m_tvalid` is high and `m_tready` is low, the output beat holds every field stable on the next cycle. Backpressure never drops a beat and never duplicates one.
- R4: At most one input ready is high in any cycle. Once an input has a beat accepted with its end flag low, the other input's ready stays low until that input's end-flag beat is accepted.
- R5: Ownership passes from controlled to uncontrolled only under three conditions. `u_tvalid` is high, no controlled packet is part-way through, and `c_tvalid` has been low for `IDLE_GAP`+1 consecutive cycles (default 7), counting the cycle in which the decision is made. With `m_tready` held high, the first uncontrolled beat sees `u_tready` high in the `IDLE_GAP`+2nd cycle (default 8th) after the cycle in which the controlled end-flag beat was accepted.
- R6: A controlled valid beat during the idle gap restarts the gap. The uncontrolled wait is then measured from the last controlled end-flag beat, as in R5.
- R7: In the cycle after an uncontrolled end-flag beat is accepted, `u_tready` is low. A waiting controlled source sees `c_tready` high in that same cycle when the output is free.
- R8: While `unc_en` is low, `u_tready` stays low whatever `u_tvalid` does, and controlled traffic flows normally.
- R9: During reset and immediately after it, `m_tvalid` is low and `u_tready` is low. Once reset is released with the output empty, `c_tready` is high.
- R10: A controlled packet that becomes valid while the uncontrolled source owns the output waits for the uncontrolled end-flag beat. It cannot preempt the uncontrolled source mid-packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unc_en | input | 1 | Enables the uncontrolled input |
| c_tdata | input | DATA_W | Controlled data |
| c_tkeep | input | DATA_W/8 | Controlled byte enables |
| c_tlast | input | 1 | Controlled end of packet |
| c_tid | input | ID_W | Controlled stream identifier |
| c_tuser | input | 16 | Controlled metadata |
| c_tvalid | input | 1 | Controlled beat valid |
| c_tready | output | 1 | Controlled beat accepted |
| u_tdata | input | DATA_W | Uncontrolled data |
| u_tkeep | input | DATA_W/8 | Uncontrolled byte enables |
| u_tlast | input | 1 | Uncontrolled end of packet |
| u_tid | input | ID_W | Uncontrolled stream identifier |
| u_tuser | input | 16 | Uncontrolled metadata |
| u_tvalid | input | 1 | Uncontrolled beat valid |
| u_tready | output | 1 | Uncontrolled beat accepted |
| m_tdata | output | DATA_W | Merged data |
| m_tkeep | output | DATA_W/8 | Merged byte enables |
| m_tlast | output | 1 | Merged end of packet |
| m_tid | output | ID_W | Merged stream identifier |
| m_tuser | output | 16 | Merged metadata |
| m_tvalid | output | 1 | Merged beat valid |
| m_tready | input | 1 | Downstream accepts beat |

## Verification
The bench measures the exact cycle distance between the last controlled end-flag beat and the first uncontrolled grant. An off-by-one idle counter shows up there as a wait of 7 or 9 cycles instead of 8. A counter that misses a controlled beat during the gap grants far too early. A further test holds the uncontrolled source mid-packet with a hole in its valid while controlled traffic arrives. A design that preempts there, or one that returns ownership late, breaks the measured one-cycle hand-back or splits a packet on the output. Random output backpressure with both sources active catches a register stage that drops, repeats or changes a stalled beat.

// File: rtl/txm_pkg.sv
package txm_pkg;
   typedef enum logic {
      OWN_CTRL = 1'b0,
      OWN_UNC  = 1'b1
   } owner_e;

   localparam int META_W = 16;
endpackage

// File: rtl/txm_idle_timer.sv
// Counts consecutive cycles without a controlled valid beat.
module txm_idle_timer #(
   parameter int GAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic c_tvalid,
   output logic gap_met
);
   localparam int CW = $clog2(GAP + 1);
   localparam logic [CW-1:0] GAP_V = CW'(GAP);

   if (GAP < 1) begin : g_bad_gap
      $error("txm_idle_timer: GAP must be at least 1");
   end

   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               quiet_q <= '0;
      else if (c_tvalid)        quiet_q <= '0;
      else if (quiet_q != GAP_V) quiet_q <= quiet_q + 1'b1;
   end

   // previous GAP idle cycles plus the present one
   assign gap_met = !c_tvalid && (quiet_q == GAP_V);
endmodule

// File: rtl/txm_owner.sv
// Ownership state: switches only between packets.
module txm_owner
   import txm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   unc_en,
   input  logic   gap_met,
   input  logic   u_tvalid,
   input  logic   c_fire,
   input  logic   u_fire,
   input  logic   beat_last,
   output owner_e owner
);
   owner_e own_q, own_n;
   logic   mid_q, mid_n;

   always_comb begin
      own_n = own_q;
      mid_n = mid_q;
      case (own_q)
         OWN_CTRL: begin
            if (c_fire)
               mid_n = !beat_last;
            else if (!mid_q && gap_met && unc_en && u_tvalid)
               own_n = OWN_UNC;
         end
         default: begin
            if (u_fire) begin
               mid_n = !beat_last;
               if (beat_last) own_n = OWN_CTRL;
            end else if (!unc_en && !mid_q) begin
               own_n = OWN_CTRL;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= OWN_CTRL;
         mid_q <= 1'b0;
      end else begin
         own_q <= own_n;
         mid_q <= mid_n;
      end
   end

   assign owner = own_q;
endmodule

// File: rtl/txm_out_stage.sv
// Single full-throughput register slice.
module txm_out_stage #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         out_ready,
   output logic         load_ok,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   assign load_ok = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load_ok) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/txm_merge.sv
module txm_merge
   import txm_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int ID_W     = 4,
   parameter bit META_EN  = 1'b1,
   parameter int IDLE_GAP = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                unc_en,
   input  logic [DATA_W-1:0]   c_tdata,
   input  logic [DATA_W/8-1:0] c_tkeep,
   input  logic                c_tlast,
   input  logic [ID_W-1:0]     c_tid,
   input  logic [15:0]         c_tuser,
   input  logic                c_tvalid,
   output logic                c_tready,
   input  logic [DATA_W-1:0]   u_tdata,
   input  logic [DATA_W/8-1:0] u_tkeep,
   input  logic                u_tlast,
   input  logic [ID_W-1:0]     u_tid,
   input  logic [15:0]         u_tuser,
   input  logic                u_tvalid,
   output logic                u_tready,
   output logic [DATA_W-1:0]   m_tdata,
   output logic [DATA_W/8-1:0] m_tkeep,
   output logic                m_tlast,
   output logic [ID_W-1:0]     m_tid,
   output logic [15:0]         m_tuser,
   output logic                m_tvalid,
   input  logic                m_tready
);
   localparam int KEEP_W = DATA_W / 8;
   localparam int PW     = META_W + ID_W + 1 + KEEP_W + DATA_W;

   if (!(DATA_W == 64 || DATA_W == 128 || DATA_W == 256 || DATA_W == 512)) begin : g_bad_width
      $error("txm_merge: DATA_W must be 64, 128, 256 or 512");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("txm_merge: ID_W must be at least 1");
   end

   owner_e          owner;
   logic            gap_met, load_ok, sel_valid, sel_last, c_fire, u_fire;
   logic [15:0]     c_meta, u_meta;
   logic [PW-1:0]   c_pl, u_pl, sel_pl, out_pl;

   if (META_EN) begin : g_meta
      assign c_meta = c_tuser;
      assign u_meta = u_tuser;
   end else begin : g_nometa
      assign c_meta = '0;
      assign u_meta = '0;
   end

   assign c_pl = {c_meta, c_tid, c_tlast, c_tkeep, c_tdata};
   assign u_pl = {u_meta, u_tid, u_tlast, u_tkeep, u_tdata};

   always_comb begin
      if (owner == OWN_CTRL) begin
         sel_pl    = c_pl;
         sel_valid = c_tvalid;
         sel_last  = c_tlast;
      end else begin
         sel_pl    = u_pl;
         sel_valid = u_tvalid && unc_en;
         sel_last  = u_tlast;
      end
   end

   assign c_tready = (owner == OWN_CTRL) && load_ok;
   assign u_tready = unc_en && (owner == OWN_UNC) && load_ok;
   assign c_fire   = c_tvalid && c_tready;
   assign u_fire   = u_tvalid && u_tready;

   txm_idle_timer #(.GAP(IDLE_GAP)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .c_tvalid (c_tvalid),
      .gap_met  (gap_met)
   );

   txm_owner u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .unc_en    (unc_en),
      .gap_met   (gap_met),
      .u_tvalid  (u_tvalid),
      .c_fire    (c_fire),
      .u_fire    (u_fire),
      .beat_last (sel_last),
      .owner     (owner)
   );

   txm_out_stage #(.W(PW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sel_valid),
      .in_data   (sel_pl),
      .out_ready (m_tready),
      .load_ok   (load_ok),
      .out_valid (m_tvalid),
      .out_data  (out_pl)
   );

   assign {m_tuser, m_tid, m_tlast, m_tkeep, m_tdata} = out_pl;
endmodule

// File: rtl/txm_merge_chk.sv
module txm_merge_chk #(
   parameter int DATA_W = 64,
   parameter int ID_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              unc_en,
   input logic              c_tvalid,
   input logic              c_tready,
   input logic              c_tlast,
   input logic              u_tvalid,
   input logic              u_tready,
   input logic              u_tlast,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              m_tlast,
   input logic [DATA_W-1:0] m_tdata,
   input logic [ID_W-1:0]   m_tid,
   input logic [15:0]       m_tuser
);
   logic c_mid, u_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_mid <= 1'b0;
         u_mid <= 1'b0;
      end else begin
         if (c_tvalid && c_tready) c_mid <= !c_tlast;
         if (u_tvalid && u_tready) u_mid <= !u_tlast;
      end
   end

   a_r4_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(c_tready && u_tready));

   a_r4_ctrl_whole: assert property (@(posedge clk) disable iff (!rst_n)
      c_mid |-> !u_tready);

   a_r4_unc_whole: assert property (@(posedge clk) disable iff (!rst_n)
      u_mid |-> !c_tready);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)
                                   && $stable(m_tid) && $stable(m_tuser)));

   a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !unc_en |-> !u_tready);

   a_r7_hand_back: assert property (@(posedge clk) disable iff (!rst_n)
      (u_tvalid && u_tready && u_tlast) |=> !u_tready);
endmodule

bind txm_merge txm_merge_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .unc_en   (unc_en),
   .c_tvalid (c_tvalid),
   .c_tready (c_tready),
   .c_tlast  (c_tlast),
   .u_tvalid (u_tvalid),
   .u_tready (u_tready),
   .u_tlast  (u_tlast),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tlast  (m_tlast),
   .m_tdata  (m_tdata),
   .m_tid    (m_tid),
   .m_tuser  (m_tuser)
);

// File: tb/sim_txm_merge.sv
`timescale 1ns/1ps
module sim_txm_merge;
   localparam int DW  = 64;
   localparam int IW  = 4;
   localparam int GAP = 6;

   typedef struct packed {
      logic [DW-1:0]   data;
      logic [DW/8-1:0] keep;
      logic            last;
      logic [IW-1:0]   tid;
      logic [15:0]     user;
   } beat_t;

   logic clk = 1'b0, rst_n = 1'b0, unc_en = 1'b0, m_tready = 1'b1, bp_on = 1'b0;
   logic [DW-1:0] c_tdata = '0, u_tdata = '0, m_tdata;
   logic [DW/8-1:0] c_tkeep = '0, u_tkeep = '0, m_tkeep;
   logic c_tlast = 0, u_tlast = 0, m_tlast, c_tvalid = 0, u_tvalid = 0, m_tvalid, c_tready, u_tready;
   logic [IW-1:0] c_tid = '0, u_tid = '0, m_tid;
   logic [15:0] c_tuser = '0, u_tuser = '0, m_tuser;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int first_rdy[2], last_acc[2];
   bit u_go = 0;
   beat_t q_c[$], q_u[$];
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   txm_merge #(.DATA_W(DW), .ID_W(IW), .META_EN(1'b1), .IDLE_GAP(GAP)) u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_tready = bp_on ? (lfsr[0] | lfsr[1]) : 1'b1;
   end

   task automatic put(input bit src, input beat_t b, input logic v);
      if (src) begin
         {u_tdata, u_tkeep, u_tlast, u_tid, u_tuser} = b;
         u_tvalid = v;
      end else begin
         {c_tdata, c_tkeep, c_tlast, c_tid, c_tuser} = b;
         c_tvalid = v;
      end
   endtask

   // called at a falling edge; returns at a falling edge with valid low
   task automatic send(input bit src, input int pkt, input int len, input int hole);
      beat_t b;
      for (int i = 0; i < len; i++) begin
         b.data = {8'(src), 24'(pkt), 32'(i)};
         b.keep = (i == len - 1) ? 8'h0F : 8'hFF;
         b.last = (i == len - 1);
         b.tid  = IW'(pkt + 3 * src);
         b.user = 16'(pkt * 37 + i + src);
         put(src, b, 1'b1);
         while (1) begin
            #1;
            if (src ? u_tready : c_tready) break;
            @(negedge clk);
         end
         if (src) q_u.push_back(b); else q_c.push_back(b);
         if (i == 0) begin
            first_rdy[src] = cyc;
            if (src) u_go = 1'b1;
         end
         last_acc[src] = cyc;
         @(negedge clk);
         if (i == 0 && hole > 0) begin
            put(src, b, 1'b0);
            repeat (hole) @(negedge clk);
         end
      end
      put(src, b, 1'b0);
   endtask

   // scoreboard monitor
   bit stall_prev = 0, in_pkt = 0;
   logic [7:0] cur_src = '0;
   beat_t prev_b;
   always @(negedge clk) begin
      beat_t got, e;
      #2;
      got = {m_tdata, m_tkeep, m_tlast, m_tid, m_tuser};
      if (rst_n) begin
         if (stall_prev)
            chk(m_tvalid && got == prev_b, "R3 stalled beat held", got.data, prev_b.data);
         if (m_tvalid && m_tready) begin
            chk(!(in_pkt && m_tdata[63:56] != cur_src), "R4 no interleave", 64'(m_tdata[63:56]), 64'(cur_src));
            cur_src = m_tdata[63:56];
            in_pkt  = !m_tlast;
            if ((m_tdata[63:56] == 8'd1) ? q_u.size() == 0 : q_c.size() == 0) begin
               chk(1'b0, "R1 unexpected beat", got.data, 64'd0);
            end else begin
               e = (m_tdata[63:56] == 8'd1) ? q_u.pop_front() : q_c.pop_front();
               chk(got.data == e.data && got.keep == e.keep && got.last == e.last && got.tid == e.tid,
                   "R1 beat fields/order", got.data, e.data);
               chk(got.user == e.user, "R2 metadata", 64'(got.user), 64'(e.user));
            end
         end
         stall_prev = m_tvalid && !m_tready;
         prev_b     = got;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
      summary();
   end

   initial begin
      int bad;
      // R9: reset state
      repeat (4) @(negedge clk);
      #1 chk(m_tvalid == 1'b0, "R9 m_tvalid in reset", 64'(m_tvalid), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(m_tvalid == 1'b0, "R9 m_tvalid after reset", 64'(m_tvalid), 64'd0);
      chk(u_tready == 1'b0, "R9 u_tready after reset", 64'(u_tready), 64'd0);
      chk(c_tready == 1'b1, "R9 c_tready after reset", 64'(c_tready), 64'd1);
      @(negedge clk);

      // R8: uncontrolled disabled, beat offered but never granted
      bad = 0;
      u_tdata = '1; u_tvalid = 1'b1;
      fork
         begin
            send(0, 1, 3, 0);
            send(0, 2, 1, 0);
            send(0, 3, 2, 0);
         end
         begin
            repeat (30) begin @(negedge clk); #1; if (u_tready) bad++; end
         end
      join
      chk(bad == 0, "R8 u_tready while disabled", 64'(bad), 64'd0);
      u_tvalid = 1'b0;
      repeat (3) @(negedge clk);

      // R5: grant distance after controlled end beat
      unc_en = 1'b1;
      send(0, 4, 3, 0);
      send(1, 50, 2, 0);
      chk(first_rdy[1] - last_acc[0] == GAP + 2, "R5 idle-gap grant cycle",
          64'(first_rdy[1] - last_acc[0]), 64'(GAP + 2));

      // R6: controlled beat inside the gap restarts it
      send(0, 5, 1, 0);
      fork
         begin repeat (3) @(negedge clk); send(0, 6, 1, 0); end
         send(1, 51, 2, 0);
      join
      chk(first_rdy[1] - last_acc[0] == GAP + 2, "R6 gap restarted",
          64'(first_rdy[1] - last_acc[0]), 64'(GAP + 2));

      // R7 / R10: controlled arrives mid uncontrolled packet
      u_go = 1'b0;
      fork
         send(1, 52, 4, 3);
         begin wait (u_go); @(negedge clk); send(0, 7, 2, 0); end
      join
      chk(first_rdy[0] == last_acc[1] + 1, "R7 hand back next cycle",
          64'(first_rdy[0]), 64'(last_acc[1] + 1));
      chk(first_rdy[0] > last_acc[1], "R10 no preemption",
          64'(first_rdy[0]), 64'(last_acc[1]));

      // R3 / R1: mixed traffic under random backpressure
      bp_on = 1'b1;
      fork
         for (int p = 0; p < 8; p++) begin
            send(0, 10 + p, 1 + p % 4, 0);
            repeat (p % 9) @(negedge clk);
         end
         for (int p = 0; p < 8; p++) begin
            send(1, 100 + p, 1 + (p * 3) % 5, (p % 2) * 2);
            repeat (p % 5) @(negedge clk);
         end
      join
      bp_on = 1'b0;
      repeat (20) @(negedge clk);
      chk(q_c.size() == 0 && q_u.size() == 0, "R1 all beats delivered",
          64'(q_c.size() + q_u.size()), 64'd0);
      summary();
   end
endmodule